// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block sits between the host CPU bus and a tile-based video processor. The CPU sees eight byte-wide registers, selected by the three low address bits. Upstream decode asserts chip select across the whole 8 KB window, so the registers repeat every 8 bytes. The block keeps the control and mask bytes, the two scroll values and the 14-bit video-memory pointer, and drives them to the renderer. It reports frame status back to the CPU and raises an interrupt line at the start of the blanking interval.

Scroll and pointer loads each take two CPU writes, and they share one first/second phase toggle. A status read resets that toggle. The data register turns every CPU access into a video-memory request at the current pointer. The pointer then steps by 1 or by 32, as a control bit selects. A separate pointer and data register let the CPU write sprite memory one byte at a time.

Every CPU access completes in a single clock cycle. Read data appears on `rdata` in the cycle that follows the access and holds until the next read. Video memory is expected to return read data one cycle after a request.

Top module: `vdp_cpu_port`

## Requirements
- R1: After synchronous reset, the following are all zero: control, mask, both scroll values, the video pointer, the sprite pointer and `rdata`. The shared toggle is in its first phase and `nmi` is low.
- R2: A write with `reg_sel`=0 loads the control byte and `reg_sel`=1 loads the mask byte, both visible on their outputs after the clock edge. Control bit 7 enables the interrupt and bit 2 selects a pointer step of 32. Bit 5 sets sprite height, bit 4 selects the background table, bit 3 selects the sprite table and bits 1:0 select the nametable. Writes to `reg_sel`=2 are ignored.
- R3: A read with `reg_sel`=2 returns the status byte in the following cycle: vblank flag in bit 7, `sprite_zero_hit` in bit 6, `sprite_overflow` in bit 5, and zeros in bits 4:0. The read clears the vblank flag. The flag is set by `vblank_set` and cleared by `vblank_clr`, and `vblank_set` wins over any clear in the same cycle.
- R4: The scroll register (`reg_sel`=5) and the pointer register (`reg_sel`=6) share one phase toggle. Each write to either register flips it, and a status read returns it to the first phase.
- R5: A first-phase write to `reg_sel`=5 loads `scroll_x`. A second-phase write loads `scroll_y`.
- R6: A first-phase write to `reg_sel`=6 keeps bits 5:0 as the pending high part and leaves `vram_addr` unchanged. The second-phase write loads `vram_addr` with {pending, written byte}.
- R7: A write with `reg_sel`=7 asserts `vram_req` and `vram_we` in that same cycle, with `vram_addr` at the current pointer and `vram_wdata` equal to the written byte. The pointer then advances by 1, or by 32 when control bit 2 is set.
- R8: A read with `reg_sel`=7 asserts `vram_req` with `vram_we` low at the current pointer. The following cycle `rdata` shows the byte that video memory returns, and the pointer advances as in R7.
- R9: The pointer is 14 bits wide and wraps modulo 16384 on an advance.
- R10: `nmi` is high exactly while the vblank flag and control bit 7 are both set.
- R11: A write to `reg_sel`=3 loads the 8-bit sprite pointer. A write to `reg_sel`=4 asserts `spr_we` in that cycle with `spr_addr` at the pointer and `spr_wdata` equal to the byte, then increments the pointer, wrapping from 255 to 0.
- R12: A read of any register other than 2 and 7 returns zero and changes no state. A cycle without `cs` changes no register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Access strobe for this cycle |
| reg_sel | input | 3 | Register select (low CPU address bits) |
| rd_en | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | CPU write byte |
| rdata | output | 8 | CPU read byte, valid the cycle after a read |
| vblank_set | input | 1 | Renderer pulse: blanking interval starts |
| vblank_clr | input | 1 | Renderer pulse: blanking interval ends |
| sprite_zero_hit | input | 1 | Renderer status level |
| sprite_overflow | input | 1 | Renderer status level |
| nmi | output | 1 | Interrupt request to the CPU |
| ctrl_out | output | 8 | Control byte |
| mask_out | output | 8 | Mask byte |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll |
| vram_req | output | 1 | Video-memory request strobe |
| vram_we | output | 1 | Request is a write |
| vram_addr | output | 14 | Current video pointer |
| vram_wdata | output | 8 | Video-memory write byte |
| vram_rdata | input | 8 | Video-memory read byte, one cycle after a request |
| spr_we | output | 1 | Sprite-memory write strobe |
| spr_addr | output | 8 | Sprite pointer |
| spr_wdata | output | 8 | Sprite-memory write byte |

## Verification
The assertions assume that `rst` is held for at least one edge, that `reg_sel` and `rd_en` are stable and known whenever `cs` is high, and that video memory answers a read one cycle after the request. The pointer-step and status-clear properties also need the renderer strobes to be quiet in the checked cycle. The random stimulus picks registers, directions and data uniformly, and pulses the two vblank strobes only rarely. The bench drives every access from a task at the falling edge, so each access lasts exactly one cycle. A synchronous memory model in the bench answers reads with the same one-cycle latency. Directed cases cover the collision between a set pulse and a status read, the toggle reset, and pointer wraparound at both step sizes.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;
    localparam int DATA_W      = 8;
    localparam int VADDR_W     = 14;
    localparam int SADDR_W     = 8;
    localparam int STRIDE_WIDE = 32;
    localparam int STRIDE_NARW = 1;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_MASK = 3'd1,
        SEL_STAT = 3'd2,
        SEL_SPRA = 3'd3,
        SEL_SPRD = 3'd4,
        SEL_SCRL = 3'd5,
        SEL_VADR = 3'd6,
        SEL_DATA = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic       nmi_en;
        logic       spare;
        logic       spr_tall;
        logic       bg_tbl;
        logic       spr_tbl;
        logic       inc_wide;
        logic [1:0] nt_sel;
    } ctrl_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_mask;
        logic rd_stat;
        logic wr_spra;
        logic wr_sprd;
        logic wr_scrl;
        logic wr_vadr;
        logic acc_data;
        logic rd_data;
    } strobe_t;

    function automatic strobe_t decode(input logic cs, input logic rd, input reg_sel_e sel);
        strobe_t s;
        s          = '0;
        s.wr_ctrl  = cs && !rd && (sel == SEL_CTRL);
        s.wr_mask  = cs && !rd && (sel == SEL_MASK);
        s.rd_stat  = cs &&  rd && (sel == SEL_STAT);
        s.wr_spra  = cs && !rd && (sel == SEL_SPRA);
        s.wr_sprd  = cs && !rd && (sel == SEL_SPRD);
        s.wr_scrl  = cs && !rd && (sel == SEL_SCRL);
        s.wr_vadr  = cs && !rd && (sel == SEL_VADR);
        s.acc_data = cs && (sel == SEL_DATA);
        s.rd_data  = cs &&  rd && (sel == SEL_DATA);
        return s;
    endfunction

    function automatic logic [VADDR_W-1:0] step_of(input logic wide);
        return wide ? VADDR_W'(STRIDE_WIDE) : VADDR_W'(STRIDE_NARW);
    endfunction
endpackage

// File: rtl/vdp_ctrl_regs.sv
module vdp_ctrl_regs
    import vdp_port_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic          wr_mask,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl_q,
    output logic [DW-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wdata);
            if (wr_mask) mask_q <= wdata;
        end
    end

    // R2: the control byte changes only on its own write strobe
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/vdp_addr_seq.sv
module vdp_addr_seq
    import vdp_port_pkg::*;
#(
    parameter int VAW = VADDR_W,
    parameter int DW  = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_scroll,
    input  logic           wr_vaddr,
    input  logic           data_acc,
    input  logic           inc_wide,
    input  logic           toggle_rst,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  scroll_x,
    output logic [DW-1:0]  scroll_y,
    output logic [VAW-1:0] vaddr
);
    localparam int HI_W = VAW - DW;

    logic            second_q;
    logic [HI_W-1:0] pend_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            second_q  <= 1'b0;
            pend_hi_q <= '0;
            scroll_x  <= '0;
            scroll_y  <= '0;
            vaddr     <= '0;
        end else begin
            if (toggle_rst) begin
                second_q <= 1'b0;
            end else if (wr_scroll || wr_vaddr) begin
                second_q <= !second_q;
            end
            if (wr_scroll) begin
                if (second_q) scroll_y <= wdata;
                else          scroll_x <= wdata;
            end
            if (wr_vaddr) begin
                if (second_q) vaddr     <= {pend_hi_q, wdata};
                else          pend_hi_q <= wdata[HI_W-1:0];
            end else if (data_acc) begin
                vaddr <= vaddr + step_of(inc_wide);
            end
        end
    end

    // R4: a status read always leaves the toggle in its first phase
    a_r4_toggle_reset: assert property (@(posedge clk) disable iff (rst)
        toggle_rst |=> !second_q);
    // R6: the first pointer write does not move the pointer
    a_r6_first_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_vaddr && !second_q) |=> $stable(vaddr));
    // R7, R9: narrow step is +1 modulo the pointer width
    a_r7_step_narrow: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !inc_wide) |=> (vaddr == VAW'($past(vaddr) + VAW'(1))));
    // R7, R9: wide step is +32 modulo the pointer width
    a_r9_step_wide: assert property (@(posedge clk) disable iff (rst)
        (data_acc && inc_wide) |=> (vaddr == VAW'($past(vaddr) + VAW'(32))));
endmodule

// File: rtl/vdp_spr_port.sv
module vdp_spr_port
    import vdp_port_pkg::*;
#(
    parameter int SAW = SADDR_W,
    parameter int DW  = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_addr,
    input  logic           wr_data,
    input  logic [DW-1:0]  wdata,
    output logic           spr_we,
    output logic [SAW-1:0] spr_addr,
    output logic [DW-1:0]  spr_wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            spr_addr <= '0;
        end else if (wr_addr) begin
            spr_addr <= wdata[SAW-1:0];
        end else if (wr_data) begin
            spr_addr <= spr_addr + SAW'(1);
        end
    end

    assign spr_we    = wr_data;
    assign spr_wdata = wdata;

    // R11: each sprite data write moves the pointer by one with wraparound
    a_r11_spr_inc: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> (spr_addr == SAW'($past(spr_addr) + SAW'(1))));
endmodule

// File: rtl/vdp_status.sv
module vdp_status
    import vdp_port_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vblank_set,
    input  logic          vblank_clr,
    input  logic          rd_status,
    input  logic          hit,
    input  logic          ovf,
    input  logic          nmi_en,
    output logic [DW-1:0] status_byte,
    output logic          nmi
);
    logic vbl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vbl_q <= 1'b0;
        end else if (vblank_set) begin
            vbl_q <= 1'b1;
        end else if (vblank_clr || rd_status) begin
            vbl_q <= 1'b0;
        end
    end

    assign status_byte = {vbl_q, hit, ovf, {(DW-3){1'b0}}};
    assign nmi         = vbl_q && nmi_en;

    // R3: a set pulse always leaves the flag raised
    a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
        vblank_set |=> vbl_q);
    // R3: a status read without a set pulse clears the flag
    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !vblank_set) |=> !vbl_q);
endmodule

// File: rtl/vdp_cpu_port.sv
module vdp_cpu_port
    import vdp_port_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int VAW = VADDR_W,
    parameter int SAW = SADDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs,
    input  logic [2:0]     reg_sel,
    input  logic           rd_en,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic           vblank_set,
    input  logic           vblank_clr,
    input  logic           sprite_zero_hit,
    input  logic           sprite_overflow,
    output logic           nmi,
    output logic [DW-1:0]  ctrl_out,
    output logic [DW-1:0]  mask_out,
    output logic [DW-1:0]  scroll_x,
    output logic [DW-1:0]  scroll_y,
    output logic           vram_req,
    output logic           vram_we,
    output logic [VAW-1:0] vram_addr,
    output logic [DW-1:0]  vram_wdata,
    input  logic [DW-1:0]  vram_rdata,
    output logic           spr_we,
    output logic [SAW-1:0] spr_addr,
    output logic [DW-1:0]  spr_wdata
);
    strobe_t       stb;
    ctrl_t         ctrl_q;
    logic [DW-1:0] status_byte;
    logic [DW-1:0] hold_q;
    logic          from_vram_q;

    assign stb = decode(cs, rd_en, reg_sel_e'(reg_sel));

    vdp_ctrl_regs #(.DW(DW)) u_ctrl (
        .clk(clk), .rst(rst),
        .wr_ctrl(stb.wr_ctrl), .wr_mask(stb.wr_mask), .wdata(wdata),
        .ctrl_q(ctrl_q), .mask_q(mask_out)
    );

    vdp_addr_seq #(.VAW(VAW), .DW(DW)) u_seq (
        .clk(clk), .rst(rst),
        .wr_scroll(stb.wr_scrl), .wr_vaddr(stb.wr_vadr),
        .data_acc(stb.acc_data), .inc_wide(ctrl_q.inc_wide),
        .toggle_rst(stb.rd_stat), .wdata(wdata),
        .scroll_x(scroll_x), .scroll_y(scroll_y), .vaddr(vram_addr)
    );

    vdp_spr_port #(.SAW(SAW), .DW(DW)) u_spr (
        .clk(clk), .rst(rst),
        .wr_addr(stb.wr_spra), .wr_data(stb.wr_sprd), .wdata(wdata),
        .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata)
    );

    vdp_status #(.DW(DW)) u_stat (
        .clk(clk), .rst(rst),
        .vblank_set(vblank_set), .vblank_clr(vblank_clr),
        .rd_status(stb.rd_stat), .hit(sprite_zero_hit), .ovf(sprite_overflow),
        .nmi_en(ctrl_q.nmi_en), .status_byte(status_byte), .nmi(nmi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q      <= '0;
            from_vram_q <= 1'b0;
        end else if (cs && rd_en) begin
            from_vram_q <= stb.rd_data;
            hold_q      <= stb.rd_stat ? status_byte : '0;
        end
    end

    assign rdata      = from_vram_q ? vram_rdata : hold_q;
    assign ctrl_out   = ctrl_q;
    assign vram_req   = stb.acc_data;
    assign vram_we    = !rd_en;
    assign vram_wdata = wdata;

    // R10: a status read with no set pulse drops the interrupt
    a_r10_nmi_drop: assert property (@(posedge clk) disable iff (rst)
        (cs && rd_en && reg_sel == 3'd2 && !vblank_set) |=> !nmi);
    // R7: only data-register accesses reach video memory
    a_r7_req_only_data: assert property (@(posedge clk) disable iff (rst)
        vram_req |-> (cs && reg_sel == 3'd7));
endmodule

// File: tb/vdp_cpu_port_test.sv
`timescale 1ns/1ps
module vdp_cpu_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        vblank_set = 1'b0, vblank_clr = 1'b0;
    logic        sprite_zero_hit = 1'b0, sprite_overflow = 1'b0;
    logic        nmi;
    logic [7:0]  ctrl_out, mask_out, scroll_x, scroll_y;
    logic        vram_req, vram_we;
    logic [13:0] vram_addr;
    logic [7:0]  vram_wdata;
    logic [7:0]  vram_rdata = '0;
    logic        spr_we;
    logic [7:0]  spr_addr, spr_wdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    vdp_cpu_port uut (.*);

    logic [7:0] dev_mem [16384];
    always @(posedge clk) begin
        if (vram_req && vram_we)  dev_mem[vram_addr] <= vram_wdata;
        if (vram_req && !vram_we) vram_rdata <= dev_mem[vram_addr];
    end

    logic [7:0]  e_mem [16384];
    logic [7:0]  e_ctrl, e_mask, e_sx, e_sy, e_sa, e_rd;
    logic [5:0]  e_hi;
    logic [13:0] e_va;
    logic        e_vbl, e_tog;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] adv(input logic [13:0] a, input logic [7:0] c);
        return c[2] ? a + 14'd32 : a + 14'd1;
    endfunction

    task automatic op(input logic c, input logic [2:0] s, input logic r, input logic [7:0] d,
                      input logic vs, input logic vc);
        logic [7:0] exp_rd;
        @(negedge clk);
        cs = c; reg_sel = s; rd_en = r; wdata = d; vblank_set = vs; vblank_clr = vc;
        #0.5;
        chk(vram_req == (c && s == 3'd7), "R7 vram_req", vram_req, c && s == 3'd7);
        if (c && s == 3'd7) begin
            chk(vram_we == !r, "R8 vram_we", vram_we, !r);
            chk(vram_addr == e_va, "R7 request address", vram_addr, e_va);
            if (!r) chk(vram_wdata == d, "R7 vram_wdata", vram_wdata, d);
        end
        chk(spr_we == (c && !r && s == 3'd4), "R11 spr_we", spr_we, c && !r && s == 3'd4);
        if (c && !r && s == 3'd4)
            chk(spr_addr == e_sa && spr_wdata == d, "R11 sprite write", {spr_addr, spr_wdata}, {e_sa, d});
        exp_rd = '0;
        if (c && r && s == 3'd2) exp_rd = {e_vbl, sprite_zero_hit, sprite_overflow, 5'b0};
        if (c && r && s == 3'd7) exp_rd = e_mem[e_va];
        if (c && !r) begin
            case (s)
                3'd0: e_ctrl = d;
                3'd1: e_mask = d;
                3'd3: e_sa = d;
                3'd4: e_sa = e_sa + 8'd1;
                3'd5: begin if (e_tog) e_sy = d; else e_sx = d; e_tog = !e_tog; end
                3'd6: begin if (e_tog) e_va = {e_hi, d}; else e_hi = d[5:0]; e_tog = !e_tog; end
                3'd7: begin e_mem[e_va] = d; e_va = adv(e_va, e_ctrl); end
                default: ;
            endcase
        end
        if (c && r && s == 3'd7) e_va = adv(e_va, e_ctrl);
        if (c && r && s == 3'd2) e_tog = 1'b0;
        if (vs) e_vbl = 1'b1;
        else if (vc || (c && r && s == 3'd2)) e_vbl = 1'b0;
        if (c && r) e_rd = exp_rd;
        @(posedge clk);
        #0.5;
        cs = 1'b0; vblank_set = 1'b0; vblank_clr = 1'b0;
        if (c && r) begin
            if (s == 3'd2)      chk(rdata == e_rd, "R3 status byte", rdata, e_rd);
            else if (s == 3'd7) chk(rdata == e_rd, "R8 data read", rdata, e_rd);
            else                chk(rdata == e_rd, "R12 write-only read", rdata, e_rd);
        end
        chk(vram_addr == e_va, "R6 pointer", vram_addr, e_va);
        chk(ctrl_out == e_ctrl && mask_out == e_mask, "R2 ctrl/mask", {ctrl_out, mask_out}, {e_ctrl, e_mask});
        chk(scroll_x == e_sx && scroll_y == e_sy, "R5 scroll", {scroll_x, scroll_y}, {e_sx, e_sy});
        chk(spr_addr == e_sa, "R11 sprite pointer", spr_addr, e_sa);
        chk(nmi == (e_vbl && e_ctrl[7]), "R10 nmi", nmi, e_vbl && e_ctrl[7]);
    endtask

    task automatic set_ptr(input logic [13:0] a);
        op(1, 3'd2, 1, 8'h00, 0, 0);
        op(1, 3'd6, 0, {2'b00, a[13:8]}, 0, 0);
        op(1, 3'd6, 0, a[7:0], 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16384; i++) begin dev_mem[i] = 8'h00; e_mem[i] = 8'h00; end
        e_ctrl = 0; e_mask = 0; e_sx = 0; e_sy = 0; e_sa = 0; e_rd = 0;
        e_hi = 0; e_va = 0; e_vbl = 0; e_tog = 0;
        void'($urandom(32'h1357_2468));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #0.5;
        // R1 reset state
        chk(vram_addr == 0 && spr_addr == 0 && rdata == 0, "R1 reset pointers", {vram_addr, spr_addr, rdata}, 0);
        chk(ctrl_out == 0 && mask_out == 0 && scroll_x == 0 && scroll_y == 0 && !nmi,
            "R1 reset regs", {ctrl_out, mask_out, scroll_x, scroll_y}, 0);

        // R4: toggle returns to first phase after a status read
        op(1, 3'd6, 0, 8'h12, 0, 0);
        op(1, 3'd2, 1, 8'h00, 0, 0);
        op(1, 3'd6, 0, 8'h05, 0, 0);
        op(1, 3'd6, 0, 8'hA0, 0, 0);
        chk(vram_addr == 14'h05A0, "R4 toggle reset", vram_addr, 14'h05A0);

        // R3: set pulse wins over a same-cycle status read
        sprite_zero_hit = 1'b1;
        op(1, 3'd0, 0, 8'h80, 1, 0);
        op(1, 3'd2, 1, 8'h00, 1, 0);
        chk(nmi == 1'b1, "R3 set beats read clear", nmi, 1);
        op(1, 3'd2, 1, 8'h00, 0, 0);
        chk(rdata == 8'hC0, "R3 status bits", rdata, 8'hC0);
        sprite_zero_hit = 1'b0;

        // R9: wrap at both step sizes
        op(1, 3'd0, 0, 8'h00, 0, 0);
        set_ptr(14'h3FFF);
        op(1, 3'd7, 0, 8'h5A, 0, 0);
        chk(vram_addr == 14'h0000, "R9 narrow wrap", vram_addr, 0);
        op(1, 3'd0, 0, 8'h04, 0, 0);
        set_ptr(14'h3FF0);
        op(1, 3'd7, 1, 8'h00, 0, 0);
        chk(vram_addr == 14'h0010, "R9 wide wrap", vram_addr, 14'h0010);

        // R11: sprite pointer wrap
        op(1, 3'd3, 0, 8'hFF, 0, 0);
        op(1, 3'd4, 0, 8'h33, 0, 0);
        chk(spr_addr == 8'h00, "R11 sprite wrap", spr_addr, 0);

        // R8: read back a written location
        op(1, 3'd0, 0, 8'h00, 0, 0);
        set_ptr(14'h0123);
        op(1, 3'd7, 0, 8'hC3, 0, 0);
        set_ptr(14'h0123);
        op(1, 3'd7, 1, 8'h00, 0, 0);
        chk(rdata == 8'hC3, "R8 readback", rdata, 8'hC3);

        // random mix, including R12 idle cycles and write-only reads
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] d;
            d = 8'($urandom);
            sprite_zero_hit = 1'($urandom);
            sprite_overflow = 1'($urandom);
            op(($urandom % 8) != 0, 3'($urandom), 1'($urandom), d,
               ($urandom % 32) == 0, ($urandom % 32) == 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule